// File: doc/BRIEF.md
# Luma/Chroma Word Interleaver with Sync-Code Normalizer

This block takes a video sample pair made of a 10-bit luma word and a 10-bit chroma word. It turns the pair into a single 10-bit word stream that runs at twice the pair rate. The block runs on one fast clock and is paced by a step enable, `step_en`, which is asserted once per output word slot. Within each pair the chroma word goes out first and the luma word second. The input pair is latched on the step that emits chroma, so the caller changes the inputs once per pair, at the parallel word rate.

Each outgoing word passes through a sync-code normalizer. Timing-reference codes use reserved values at the bottom (0x000–0x003) and top (0x3FC–0x3FF) of the 10-bit range. The normalizer looks only at the eight most significant bits. When those are all zero it forces the two low bits to 00, and when they are all one it forces them to 11. An 8-bit source that is left-aligned into 10 bits therefore yields the same legal sync words as a native 10-bit source. The `sync_norm_off` input disables the forcing for data that does not follow the standard.

Every output is registered. Each produced word carries a valid strobe and a flag that tells luma from chroma.

Top module: `vid_word_interleaver`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `word_out` to 0x000, `word_valid` to 0 and `word_is_luma` to 0, and sets the phase so that the next step emits chroma.
- R2: A step (`step_en` high at an edge) makes `word_valid` high after that edge. At an edge with `step_en` low, `word_valid` goes low and `word_out` and `word_is_luma` keep their values.
- R3: Steps alternate chroma then luma, starting with chroma after reset. `word_is_luma` is 0 for a chroma word and 1 for a luma word. Idle cycles between steps do not change the order.
- R4: `luma_in` and `chroma_in` are both captured at the chroma step. The luma word emitted at the following step is the captured value, whatever `luma_in` holds at that step.
- R5: With `sync_norm_off` low, a word whose bits [9:2] are all zero is emitted with bits [1:0] forced to 00.
- R6: With `sync_norm_off` low, a word whose bits [9:2] are all one is emitted with bits [1:0] forced to 11.
- R7: A word whose bits [9:2] are neither all zero nor all one is emitted unchanged.
- R8: With `sync_norm_off` high at the emitting step, every word is emitted unchanged, including reserved codes. The input is sampled at each step, so the two words of a pair may be treated differently.
- R9: Normalization applies in the same way to chroma words and luma words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, at least twice the pair rate |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Output word slot enable (2x pair rate) |
| luma_in | input | 10 | Luma half of the input pair |
| chroma_in | input | 10 | Chroma half of the input pair |
| sync_norm_off | input | 1 | High: reserved-code forcing disabled |
| word_out | output | 10 | Interleaved, normalized output word |
| word_valid | output | 1 | High for one cycle per produced word |
| word_is_luma | output | 1 | 1 = luma word, 0 = chroma word |

## Verification
The embedded assertions check the following on every cycle:
- reset clears the outputs;
- a step is followed by a valid word, and the outputs hold still on idle cycles;
- the phase flips once per step and never on idle cycles;
- a produced word whose upper bits are all zero or all one carries the forced low bits unless the disable was high.

The directed scenarios check what the cycle-level properties cannot:
- the values of the interleaved pairs;
- that the luma word is the one captured at the chroma step, even when the input changes afterwards;
- that words just outside the reserved ranges pass untouched;
- that the disable affects each word of a pair on its own;
- that the chroma-first order restarts after a mid-stream reset.

// File: rtl/vwi_pkg.sv
package vwi_pkg;
  typedef enum logic {
    PH_CHROMA = 1'b0,
    PH_LUMA   = 1'b1
  } vwi_phase_e;
endpackage

// File: rtl/vwi_pair_capture.sv
module vwi_pair_capture
  import vwi_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [WORD_W-1:0] luma_in,
  input  logic [WORD_W-1:0] chroma_in,
  output logic [WORD_W-1:0] sel_word,
  output vwi_phase_e        sel_phase
);
  vwi_phase_e        phase_q;
  logic [WORD_W-1:0] luma_hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_CHROMA;
      luma_hold_q <= '0;
    end else if (step_en) begin
      if (phase_q == PH_CHROMA) begin
        luma_hold_q <= luma_in;
        phase_q     <= PH_LUMA;
      end else begin
        phase_q     <= PH_CHROMA;
      end
    end
  end

  always_comb begin
    sel_phase = phase_q;
    sel_word  = (phase_q == PH_CHROMA) ? chroma_in : luma_hold_q;
  end

  // R3
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (phase_q != $past(phase_q)));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> (phase_q == $past(phase_q)));

  // R4
  luma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && phase_q == PH_LUMA) |=> $stable(luma_hold_q));
endmodule

// File: rtl/vwi_sync_norm.sv
module vwi_sync_norm #(
  parameter int WORD_W = 10,
  parameter int LSB_W  = 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              bypass_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int HI_W = WORD_W - LSB_W;

  generate
    if (LSB_W == 0) begin : g_pass
      logic unused_bypass;
      assign unused_bypass = bypass_i;
      assign word_o = word_i;
    end else begin : g_norm
      logic [HI_W-1:0] hi;
      logic            hi_zero;
      logic            hi_ones;
      assign hi      = word_i[WORD_W-1:LSB_W];
      assign hi_zero = (hi == '0);
      assign hi_ones = (hi == {HI_W{1'b1}});
      always_comb begin
        word_o = word_i;
        if (!bypass_i) begin
          if (hi_zero)      word_o[LSB_W-1:0] = '0;
          else if (hi_ones) word_o[LSB_W-1:0] = '1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/vwi_out_stage.sv
module vwi_out_stage
  import vwi_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int LSB_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              norm_off,
  input  logic [WORD_W-1:0] word_d,
  input  vwi_phase_e        phase_d,
  output logic [WORD_W-1:0] word_q,
  output logic              valid_q,
  output logic              is_luma_q
);
  localparam int HI_W = WORD_W - LSB_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      valid_q   <= 1'b0;
      is_luma_q <= 1'b0;
    end else begin
      valid_q <= step_en;
      if (step_en) begin
        word_q    <= word_d;
        is_luma_q <= (phase_d == PH_LUMA);
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (word_q == '0 && !valid_q && !is_luma_q));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> valid_q);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> (!valid_q && $stable(word_q) && $stable(is_luma_q)));

  // R5
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !norm_off && word_d[WORD_W-1:LSB_W] == '0)
      |=> (word_q[LSB_W-1:0] == '0));

  // R6
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !norm_off && word_d[WORD_W-1:LSB_W] == {HI_W{1'b1}})
      |=> (word_q[LSB_W-1:0] == {LSB_W{1'b1}}));
endmodule

// File: rtl/vid_word_interleaver.sv
module vid_word_interleaver
  import vwi_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int LSB_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [WORD_W-1:0] luma_in,
  input  logic [WORD_W-1:0] chroma_in,
  input  logic              sync_norm_off,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              word_is_luma
);
  logic [WORD_W-1:0] raw_word;
  logic [WORD_W-1:0] norm_word;
  vwi_phase_e        cur_phase;

  vwi_pair_capture #(.WORD_W(WORD_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .luma_in   (luma_in),
    .chroma_in (chroma_in),
    .sel_word  (raw_word),
    .sel_phase (cur_phase)
  );

  vwi_sync_norm #(.WORD_W(WORD_W), .LSB_W(LSB_W)) u_norm (
    .word_i   (raw_word),
    .bypass_i (sync_norm_off),
    .word_o   (norm_word)
  );

  vwi_out_stage #(.WORD_W(WORD_W), .LSB_W(LSB_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .norm_off  (sync_norm_off),
    .word_d    (norm_word),
    .phase_d   (cur_phase),
    .word_q    (word_out),
    .valid_q   (word_valid),
    .is_luma_q (word_is_luma)
  );

  // R3
  flag_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && step_en) |=> (word_is_luma != $past(word_is_luma)));
endmodule

// File: tb/vid_word_interleaver_test.sv
module vid_word_interleaver_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       step_en;
  logic [9:0] luma_in;
  logic [9:0] chroma_in;
  logic       sync_norm_off;
  logic [9:0] word_out;
  logic       word_valid;
  logic       word_is_luma;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vid_word_interleaver uut (
    .clk(clk), .rst(rst), .step_en(step_en),
    .luma_in(luma_in), .chroma_in(chroma_in),
    .sync_norm_off(sync_norm_off),
    .word_out(word_out), .word_valid(word_valid),
    .word_is_luma(word_is_luma)
  );

  function automatic logic [9:0] model_norm(input logic [9:0] w, input logic off);
    logic [9:0] r;
    r = w;
    if (!off) begin
      if (w[9:2] == 8'h00) r[1:0] = 2'b00;
      else if (w[9:2] == 8'hFF) r[1:0] = 2'b11;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [9:0] act_w, input logic act_v,
                       input logic act_l, input logic [9:0] exp_w,
                       input logic exp_v, input logic exp_l);
    checks++;
    if (act_w !== exp_w || act_v !== exp_v || act_l !== exp_l) begin
      errors++;
      $display("FAIL %s: actual word=%h valid=%b luma=%b expected word=%h valid=%b luma=%b",
               req, act_w, act_v, act_l, exp_w, exp_v, exp_l);
    end
  endtask

  // One clock edge with the given inputs; outputs sampled at the next falling edge.
  task automatic cycle(input logic en, input logic [9:0] l, input logic [9:0] c,
                       input logic off);
    step_en = en; luma_in = l; chroma_in = c; sync_norm_off = off;
    @(negedge clk);
  endtask

  task automatic send_pair(input string req, input logic [9:0] l, input logic [9:0] c,
                           input logic off);
    cycle(1'b1, l, c, off);
    check(req, word_out, word_valid, word_is_luma, model_norm(c, off), 1'b1, 1'b0);
    cycle(1'b1, 10'h155, 10'h2AA, off);
    check(req, word_out, word_valid, word_is_luma, model_norm(l, off), 1'b1, 1'b1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cycle(1'b0, '0, '0, 1'b0);
    cycle(1'b0, '0, '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", word_out, word_valid, word_is_luma, 10'h000, 1'b0, 1'b0);
  endtask

  task automatic t_basic();
    send_pair("R3", 10'h123, 10'h2C4, 1'b0);
    send_pair("R7", 10'h004, 10'h3FB, 1'b0);
    send_pair("R7", 10'h200, 10'h0FF, 1'b0);
  endtask

  task automatic t_idle();
    logic [9:0] w;
    cycle(1'b1, 10'h1A1, 10'h0B2, 1'b0);
    check("R3", word_out, word_valid, word_is_luma, 10'h0B2, 1'b1, 1'b0);
    w = word_out;
    cycle(1'b0, 10'h3C3, 10'h3D3, 1'b0);
    check("R2", word_out, word_valid, word_is_luma, w, 1'b0, 1'b0);
    cycle(1'b0, 10'h3C3, 10'h3D3, 1'b0);
    check("R2", word_out, word_valid, word_is_luma, w, 1'b0, 1'b0);
    cycle(1'b1, 10'h3C3, 10'h3D3, 1'b0);
    check("R4", word_out, word_valid, word_is_luma, 10'h1A1, 1'b1, 1'b1);
  endtask

  task automatic t_sync();
    send_pair("R5", 10'h003, 10'h001, 1'b0);
    send_pair("R6", 10'h3FC, 10'h3FD, 1'b0);
    send_pair("R9", 10'h3FE, 10'h002, 1'b0);
    send_pair("R5", 10'h000, 10'h3FF, 1'b0);
  endtask

  task automatic t_disable();
    send_pair("R8", 10'h3FD, 10'h002, 1'b1);
    cycle(1'b1, 10'h001, 10'h3FC, 1'b1);
    check("R8", word_out, word_valid, word_is_luma, 10'h3FC, 1'b1, 1'b0);
    cycle(1'b1, 10'h0, 10'h0, 1'b0);
    check("R8", word_out, word_valid, word_is_luma, 10'h000, 1'b1, 1'b1);
  endtask

  task automatic t_midreset();
    cycle(1'b1, 10'h111, 10'h222, 1'b0);
    check("R3", word_out, word_valid, word_is_luma, 10'h222, 1'b1, 1'b0);
    do_reset();
    check("R1", word_out, word_valid, word_is_luma, 10'h000, 1'b0, 1'b0);
    send_pair("R1", 10'h0A5, 10'h35A, 1'b0);
  endtask

  initial begin
    rst = 1'b1; step_en = 1'b0; luma_in = '0; chroma_in = '0; sync_norm_off = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_idle();
    t_sync();
    t_disable();
    t_midreset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule